// File: doc/BRIEF.md
# Threshold Zero-Run Coefficient Coder

This block compresses the detail coefficients of a wavelet stage. Each accepted input group holds five signed coefficients. Any coefficient whose magnitude is below a programmable threshold is forced to zero. The resulting stream is then coded as tokens, where each token is either a count of consecutive zeros or a single nonzero coefficient. When a group is entirely zero, its five zeros are added to the open zero run and no token is produced. When a group contains any nonzero value, the open run is closed at once. The group is then unrolled token by token, so that coefficient order survives coding.

The approximation coefficients use a separate registered path that neither thresholds nor codes them. The threshold can be rewritten at any time, but a new value only takes effect at a row boundary. Because of this, every coefficient of a row is judged by the same threshold. The token output uses a valid/ready handshake. A new group is accepted only when the previous group has been fully unrolled.

Top module: `zrc_coder`

## Requirements
- R1: During reset and in the first cycle after it, `tok_valid` and `apx_out_valid` are low and `det_ready` is high.
- R2: A detail coefficient with absolute value strictly below the active threshold counts as zero. Any other coefficient is sent as a literal token carrying its original two's-complement value unchanged. A threshold of 0 therefore zeroes nothing, and a literal is never zero.
- R3: A group whose five coefficients are all zero after thresholding adds 5 to the open zero run and emits no token by itself.
- R4: When a group holding any nonzero value is taken up, an open run with a nonzero count is emitted first, as one run token. This happens before any token derived from that group.
- R5: Inside a group that holds a nonzero value, lanes are visited in order from lane 0 (`det_data` bits [COEF_W-1:0]) to lane 4. Zeros that come before a literal are sent as a run token with their count ahead of that literal. Zeros after the last literal start the new open run.
- R6: When an all-zero group brings the open run to 2^RUN_W-1 or above, a run token of exactly 2^RUN_W-1 is emitted. The excess is kept as the new open run.
- R7: A group flagged with `det_eol` is processed as usual. After that, a nonzero open run is emitted as a run token and the count restarts at zero.
- R8: A threshold write becomes active for the first group accepted after the next accepted end-of-row group. A write in the same cycle as that end-of-row accept also counts. Reset loads THR_RESET.
- R9: Each cycle with `apx_in_valid` high produces, one cycle later, `apx_out_valid` high and `apx_out_data` equal to the input. This holds whatever the token handshake is doing.
- R10: While `tok_valid` is high and `tok_ready` is low, the token fields and `tok_valid` hold steady.
- R11: Token format: `tok_is_run`=1 marks a run token, with the zero count zero-extended in `tok_val` (never 0, at most 2^RUN_W-1). `tok_is_run`=0 marks a literal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | COEF_W | New threshold (unsigned magnitude) |
| det_valid | input | 1 | Detail group offered |
| det_ready | output | 1 | Coder can take a group |
| det_eol | input | 1 | Group is the last of its row |
| det_data | input | 5*COEF_W | Five signed coefficients, lane k at bits [k*COEF_W +: COEF_W] |
| apx_in_valid | input | 1 | Approximation coefficient present |
| apx_in_data | input | APX_W | Approximation coefficient |
| apx_out_valid | output | 1 | Forwarded approximation valid |
| apx_out_data | output | APX_W | Forwarded approximation coefficient |
| tok_valid | output | 1 | Token present |
| tok_ready | input | 1 | Consumer takes the token |
| tok_is_run | output | 1 | 1 = zero-run token, 0 = literal |
| tok_val | output | COEF_W | Run count or coefficient value |

## Verification
An engine holding a wrong run count shows the error in the very next run token. That token is either a sum or a flush, and it is compared against a bench model that derives the expected sequence from the coefficients alone. A wrong lane position or a lost literal breaks token order, and the first misplaced token exposes it. A threshold latched at the wrong time turns a literal into a zero, or the reverse, in the first group of the affected row. Random backpressure exercises the hold rule on every stalled cycle.

// File: rtl/zrc_pkg.sv
package zrc_pkg;

    localparam int LANES = 5;
    localparam int IDX_W = 3;

    typedef enum logic [1:0] {
        PH_ZERO  = 2'd0,
        PH_OPEN  = 2'd1,
        PH_SCAN  = 2'd2,
        PH_FLUSH = 2'd3
    } phase_e;

    // Lowest set lane at or above 'from'; LANES when none.
    function automatic logic [IDX_W-1:0] first_nz_from(
        input logic [LANES-1:0] m,
        input logic [IDX_W-1:0] from
    );
        logic [IDX_W-1:0] r;
        r = IDX_W'(LANES);
        for (int i = LANES - 1; i >= 0; i--) begin
            if (m[i] && (IDX_W'(i) >= from)) r = IDX_W'(i);
        end
        return r;
    endfunction

    // Any set lane strictly above 'from'.
    function automatic logic nz_above(
        input logic [LANES-1:0] m,
        input logic [IDX_W-1:0] from
    );
        logic r;
        r = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (m[i] && (IDX_W'(i) > from)) r = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/zrc_thresh.sv
module zrc_thresh
    import zrc_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [LANES*W-1:0] raw,
    input  logic [W-1:0]       thr,
    output logic [LANES*W-1:0] kept,
    output logic [LANES-1:0]   nz
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [W-1:0] c;
        logic [W-1:0] mag;
        logic         drop;
        assign c    = raw[k*W +: W];
        assign mag  = c[W-1] ? (-c) : c;
        assign drop = (mag < thr);
        assign kept[k*W +: W] = drop ? '0 : c;
        assign nz[k] = !drop && (c != '0);
    end

endmodule

// File: rtl/zrc_thr_reg.sv
module zrc_thr_reg #(
    parameter int W = 12,
    parameter logic [W-1:0] THR_RESET = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         row_end,
    output logic [W-1:0] active
);

    logic [W-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= THR_RESET;
            active <= THR_RESET;
        end else begin
            if (we) pend <= wdata;
            if (row_end) active <= we ? wdata : pend;
        end
    end

endmodule

// File: rtl/zrc_apx_pass.sv
module zrc_apx_pass #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [AW-1:0] in_data,
    output logic          out_valid,
    output logic [AW-1:0] out_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end

endmodule

// File: rtl/zrc_runeng.sv
module zrc_runeng
    import zrc_pkg::*;
#(
    parameter int W     = 12,
    parameter int RUN_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_eol,
    input  logic [LANES*W-1:0] in_coef,
    input  logic [LANES-1:0]   in_nz,
    output logic               tok_valid,
    input  logic               tok_ready,
    output logic               tok_is_run,
    output logic [W-1:0]       tok_val
);

    localparam int RUN_MAX = (1 << RUN_W) - 1;

    logic             busy;
    logic [W-1:0]     coef [LANES];
    logic [LANES-1:0] mask;
    logic             eol;
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic [RUN_W-1:0] run;

    logic accept, slot_free, step;
    assign in_ready  = !busy;
    assign accept    = in_valid && !busy;
    assign slot_free = !tok_valid || tok_ready;
    assign step      = busy && slot_free;

    logic             emit, e_run, n_done, do_scan;
    logic [W-1:0]     e_val;
    phase_e           n_phase;
    logic [IDX_W-1:0] n_idx, p;
    logic [RUN_W-1:0] n_run;
    logic [RUN_W:0]   sum;
    logic             rest;

    always_comb begin
        emit    = 1'b0;
        e_run   = 1'b0;
        e_val   = '0;
        n_phase = phase;
        n_idx   = idx;
        n_run   = run;
        n_done  = 1'b0;
        do_scan = 1'b0;
        p       = first_nz_from(mask, idx);
        rest    = nz_above(mask, idx);
        sum     = {1'b0, run} + (RUN_W+1)'(LANES);
        case (phase)
            PH_ZERO: begin
                if (sum >= (RUN_W+1)'(RUN_MAX)) begin
                    emit  = 1'b1;
                    e_run = 1'b1;
                    e_val = W'(RUN_MAX);
                    n_run = RUN_W'(sum - (RUN_W+1)'(RUN_MAX));
                end else begin
                    n_run = RUN_W'(sum);
                end
                if (eol) n_phase = PH_FLUSH;
                else     n_done  = 1'b1;
            end
            PH_OPEN: begin
                if (run != '0) begin
                    emit    = 1'b1;
                    e_run   = 1'b1;
                    e_val   = W'(run);
                    n_run   = '0;
                    n_phase = PH_SCAN;
                end else begin
                    do_scan = 1'b1;
                end
            end
            PH_SCAN: do_scan = 1'b1;
            PH_FLUSH: begin
                if (run != '0) begin
                    emit  = 1'b1;
                    e_run = 1'b1;
                    e_val = W'(run);
                end
                n_run  = '0;
                n_done = 1'b1;
            end
            default: n_done = 1'b1;
        endcase
        if (do_scan) begin
            emit = 1'b1;
            if (p != idx) begin
                e_run   = 1'b1;
                e_val   = W'(p - idx);
                n_idx   = p;
                n_phase = PH_SCAN;
            end else begin
                e_run = 1'b0;
                e_val = coef[idx];
                if (rest) begin
                    n_idx   = idx + IDX_W'(1);
                    n_phase = PH_SCAN;
                end else begin
                    n_run = RUN_W'(IDX_W'(LANES - 1) - idx);
                    if (eol) n_phase = PH_FLUSH;
                    else     n_done  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            mask       <= '0;
            eol        <= 1'b0;
            phase      <= PH_ZERO;
            idx        <= '0;
            run        <= '0;
            tok_valid  <= 1'b0;
            tok_is_run <= 1'b0;
            tok_val    <= '0;
            for (int k = 0; k < LANES; k++) coef[k] <= '0;
        end else begin
            if (accept) begin
                busy  <= 1'b1;
                mask  <= in_nz;
                eol   <= in_eol;
                idx   <= '0;
                phase <= (in_nz == '0) ? PH_ZERO : PH_OPEN;
                for (int k = 0; k < LANES; k++) coef[k] <= in_coef[k*W +: W];
            end
            if (step) begin
                phase <= n_phase;
                idx   <= n_idx;
                run   <= n_run;
                if (n_done) busy <= 1'b0;
            end
            if (slot_free) begin
                tok_valid <= step && emit;
                if (step && emit) begin
                    tok_is_run <= e_run;
                    tok_val    <= e_val;
                end
            end
        end
    end

endmodule

// File: rtl/zrc_coder.sv
module zrc_coder
    import zrc_pkg::*;
#(
    parameter int COEF_W = 12,
    parameter int RUN_W  = 8,
    parameter int APX_W  = 12,
    parameter logic [COEF_W-1:0] THR_RESET = COEF_W'(4)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    thr_we,
    input  logic [COEF_W-1:0]       thr_wdata,
    input  logic                    det_valid,
    output logic                    det_ready,
    input  logic                    det_eol,
    input  logic [LANES*COEF_W-1:0] det_data,
    input  logic                    apx_in_valid,
    input  logic [APX_W-1:0]        apx_in_data,
    output logic                    apx_out_valid,
    output logic [APX_W-1:0]        apx_out_data,
    output logic                    tok_valid,
    input  logic                    tok_ready,
    output logic                    tok_is_run,
    output logic [COEF_W-1:0]       tok_val
);

    logic [COEF_W-1:0]       thr_active;
    logic [LANES*COEF_W-1:0] kept;
    logic [LANES-1:0]        nz;
    logic                    row_end;

    assign row_end = det_valid && det_ready && det_eol;

    zrc_thr_reg #(.W(COEF_W), .THR_RESET(THR_RESET)) u_thr (
        .clk    (clk),
        .rst    (rst),
        .we     (thr_we),
        .wdata  (thr_wdata),
        .row_end(row_end),
        .active (thr_active)
    );

    zrc_thresh #(.W(COEF_W)) u_cut (
        .raw (det_data),
        .thr (thr_active),
        .kept(kept),
        .nz  (nz)
    );

    zrc_runeng #(.W(COEF_W), .RUN_W(RUN_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (det_valid),
        .in_ready  (det_ready),
        .in_eol    (det_eol),
        .in_coef   (kept),
        .in_nz     (nz),
        .tok_valid (tok_valid),
        .tok_ready (tok_ready),
        .tok_is_run(tok_is_run),
        .tok_val   (tok_val)
    );

    zrc_apx_pass #(.AW(APX_W)) u_apx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (apx_in_valid),
        .in_data  (apx_in_data),
        .out_valid(apx_out_valid),
        .out_data (apx_out_data)
    );

endmodule

// File: rtl/zrc_coder_chk.sv
module zrc_coder_chk #(
    parameter int COEF_W = 12,
    parameter int RUN_W  = 8,
    parameter int APX_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              det_ready,
    input logic              apx_in_valid,
    input logic [APX_W-1:0]  apx_in_data,
    input logic              apx_out_valid,
    input logic [APX_W-1:0]  apx_out_data,
    input logic              tok_valid,
    input logic              tok_ready,
    input logic              tok_is_run,
    input logic [COEF_W-1:0] tok_val
);

    localparam logic [COEF_W-1:0] RUN_MAX = COEF_W'((1 << RUN_W) - 1);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!tok_valid && !apx_out_valid && det_ready));

    a_r10_token_hold: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && !tok_ready) |=>
            (tok_valid && $stable(tok_is_run) && $stable(tok_val)));

    a_r11_run_range: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_is_run) |-> (tok_val != '0 && tok_val <= RUN_MAX));

    a_r2_literal_nonzero: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && !tok_is_run) |-> (tok_val != '0));

    a_r9_apx_forward: assert property (@(posedge clk) disable iff (rst)
        apx_in_valid |=> (apx_out_valid && apx_out_data == $past(apx_in_data)));

    a_r9_apx_idle: assert property (@(posedge clk) disable iff (rst)
        !apx_in_valid |=> !apx_out_valid);

endmodule

bind zrc_coder zrc_coder_chk #(
    .COEF_W(COEF_W),
    .RUN_W (RUN_W),
    .APX_W (APX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .det_ready    (det_ready),
    .apx_in_valid (apx_in_valid),
    .apx_in_data  (apx_in_data),
    .apx_out_valid(apx_out_valid),
    .apx_out_data (apx_out_data),
    .tok_valid    (tok_valid),
    .tok_ready    (tok_ready),
    .tok_is_run   (tok_is_run),
    .tok_val      (tok_val)
);

// File: tb/sim_zrc_coder.sv
`timescale 1ns/1ps
module sim_zrc_coder;

    localparam int W    = 10;
    localparam int RW   = 4;
    localparam int AW   = 10;
    localparam int RMAX = (1 << RW) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            thr_we = 1'b0;
    logic [W-1:0]    thr_wdata = '0;
    logic            det_valid = 1'b0;
    logic            det_ready;
    logic            det_eol = 1'b0;
    logic [5*W-1:0]  det_data = '0;
    logic            apx_in_valid = 1'b0;
    logic [AW-1:0]   apx_in_data = '0;
    logic            apx_out_valid;
    logic [AW-1:0]   apx_out_data;
    logic            tok_valid;
    logic            tok_ready = 1'b0;
    logic            tok_is_run;
    logic [W-1:0]    tok_val;

    always #2.5 clk = ~clk;

    zrc_coder #(.COEF_W(W), .RUN_W(RW), .APX_W(AW), .THR_RESET(W'(4))) u0 (
        .clk(clk), .rst(rst), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .det_valid(det_valid), .det_ready(det_ready), .det_eol(det_eol),
        .det_data(det_data), .apx_in_valid(apx_in_valid),
        .apx_in_data(apx_in_data), .apx_out_valid(apx_out_valid),
        .apx_out_data(apx_out_data), .tok_valid(tok_valid),
        .tok_ready(tok_ready), .tok_is_run(tok_is_run), .tok_val(tok_val)
    );

    int checks = 0;
    int fails  = 0;
    int ready_pct = 100;

    bit       exp_run[$];
    int       exp_val[$];
    string    exp_tag[$];
    string    ph_tag = "";

    int m_run = 0;
    int m_thr_act = 4;
    int m_thr_pend = 4;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input bit is_run, input int val, input string tag);
        exp_run.push_back(is_run);
        exp_val.push_back(val & ((1 << W) - 1));
        exp_tag.push_back({ph_tag, " ", tag});
    endtask

    task automatic model_group(input int c[5], input bit eol);
        int v[5];
        bit any;
        int z;
        any = 0;
        for (int k = 0; k < 5; k++) begin
            int mag;
            mag = (c[k] < 0) ? -c[k] : c[k];
            v[k] = (mag < m_thr_act) ? 0 : c[k];
            if (v[k] != 0) any = 1;
        end
        if (!any) begin
            m_run += 5;
            if (m_run >= RMAX) begin
                push(1, RMAX, "R6 saturated run");
                m_run -= RMAX;
            end
        end else begin
            if (m_run > 0) push(1, m_run, "R4 open run (R3 count)");
            z = 0;
            for (int k = 0; k < 5; k++) begin
                if (v[k] == 0) z++;
                else begin
                    if (z > 0) push(1, z, "R5 short run");
                    push(0, v[k], "R2 literal");
                    z = 0;
                end
            end
            m_run = z;
        end
        if (eol) begin
            if (m_run > 0) push(1, m_run, "R7 row flush");
            m_run = 0;
            m_thr_act = m_thr_pend;
        end
    endtask

    task automatic send(input int c0, input int c1, input int c2, input int c3,
                        input int c4, input bit eol);
        int c[5];
        c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3; c[4] = c4;
        model_group(c, eol);
        @(negedge clk);
        for (int k = 0; k < 5; k++) det_data[k*W +: W] = c[k][W-1:0];
        det_eol   = eol;
        det_valid = 1'b1;
        while (!det_ready) @(negedge clk);
        @(negedge clk);
        det_valid = 1'b0;
        det_eol   = 1'b0;
    endtask

    task automatic thr_write(input int v);
        @(negedge clk);
        thr_we    = 1'b1;
        thr_wdata = W'(v);
        @(negedge clk);
        thr_we    = 1'b0;
        m_thr_pend = v;
    endtask

    task automatic apx_check(input int v);
        @(negedge clk);
        apx_in_valid = 1'b1;
        apx_in_data  = AW'(v);
        @(negedge clk);
        apx_in_valid = 1'b0;
        check(apx_out_valid === 1'b1, "R9 apx valid", int'(apx_out_valid), 1);
        check(apx_out_data === AW'(v), "R9 apx data", int'(apx_out_data), v & ((1 << AW) - 1));
        @(negedge clk);
        check(apx_out_valid === 1'b0, "R9 apx idle", int'(apx_out_valid), 0);
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (exp_run.size() > 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(exp_run.size() == 0, "R11 all expected tokens seen", exp_run.size(), 0);
    endtask

    // Monitor / scoreboard
    bit          held = 0;
    logic        held_run;
    logic [W-1:0] held_val;
    always @(negedge clk) begin
        if (!rst) begin
            if (held) begin
                check(tok_valid === 1'b1 && tok_is_run === held_run && tok_val === held_val,
                      "R10 stalled token held", int'(tok_val), int'(held_val));
            end
            tok_ready = (($urandom % 100) < ready_pct);
            held = tok_valid && !tok_ready;
            held_run = tok_is_run;
            held_val = tok_val;
            if (tok_valid && tok_ready) begin
                if (exp_run.size() == 0) begin
                    check(1'b0, "R11 unexpected token", int'(tok_val), -1);
                end else begin
                    bit    er;
                    int    ev;
                    string et;
                    er = exp_run.pop_front();
                    ev = exp_val.pop_front();
                    et = exp_tag.pop_front();
                    check(tok_is_run === er, {et, " R11 type"}, int'(tok_is_run), int'(er));
                    check(int'(tok_val) == ev, et, int'(tok_val), ev);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(tok_valid === 1'b0, "R1 tok_valid after reset", int'(tok_valid), 0);
        check(det_ready === 1'b1, "R1 det_ready after reset", int'(det_ready), 1);
        check(apx_out_valid === 1'b0, "R1 apx_out_valid after reset", int'(apx_out_valid), 0);

        apx_check(10'h155);
        apx_check(-1);

        // R3/R4/R5/R2 basic row with threshold 4
        ph_tag = "row1";
        send(0, 0, 0, 0, 0, 0);
        send(0, 3, -3, 0, 0, 0);
        send(0, 0, 7, 0, -4, 0);
        send(5, 0, 0, 0, 0, 1);
        send(9, 0, 0, 0, 0, 0);
        send(-9, 4, 0, 0, 0, 1);
        drain();

        // R6 saturation and R7 flush of all-zero row end
        ph_tag = "sat";
        send(0, 0, 0, 0, 0, 0);
        send(0, 0, 0, 0, 0, 0);
        send(0, 0, 0, 0, 0, 0);
        send(0, 0, 0, 0, 0, 0);
        send(0, 0, 0, 1, 0, 0);
        send(0, 0, 0, 0, 9, 0);
        send(0, 0, 0, 0, 0, 1);
        drain();

        // R8 threshold takes effect after next row end
        ph_tag = "R8";
        send(6, 0, 0, 0, 0, 0);
        thr_write(8);
        send(6, 0, 0, 0, 0, 0);
        send(0, 0, 0, 0, 0, 1);
        send(6, -7, 8, 0, 0, 1);
        thr_write(0);
        send(0, 1, 0, 0, 0, 1);
        send(0, 1, 0, 0, 0, 1);
        thr_write(4);
        send(0, 0, 0, 0, 0, 1);
        drain();

        // Random traffic with backpressure
        ph_tag = "rand";
        ready_pct = 60;
        for (int g = 0; g < 400; g++) begin
            int c[5];
            for (int k = 0; k < 5; k++) begin
                int r;
                r = int'($urandom % 10);
                if (r < 6) c[k] = 0;
                else if (r < 8) c[k] = int'($urandom % 8);
                else c[k] = int'($urandom % 512);
                if ($urandom % 2) c[k] = -c[k];
            end
            if (g % 37 == 5) thr_write(int'($urandom % 20));
            if (g % 50 == 7) apx_check(int'($urandom % 1024));
            send(c[0], c[1], c[2], c[3], c[4], ($urandom % 9) == 0);
        end
        send(0, 0, 0, 0, 0, 1);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule